// File: doc/BRIEF.md
# Configurable Output Macrocell with Three-State Pin Cell

This block is one output cell of a programmable logic block. It receives the sum term built by the product-term array. Static configuration selects one of two paths: a storage element (D or T behaviour) clocked by one of several global clocks, or a straight combinatorial path. A polarity bit then shapes the pin level. The block returns an internal feedback value in both modes, so a cell whose pin is not driven can still be used as buried logic.

Global clocks reach the cell as one-cycle edge strobes in the system clock domain. The storage element updates on a strobe from the selected clock only. Reset and preset terms are shared across the logic block, act on any system edge, and do not wait for the selected strobe. The pin enable comes from a fixed setting or from one of two enable terms shared by a bank of cells. Two test controls are provided. Preload writes the pin level into the register. Observe forces the pin driver on so that a buried register can be read. While either test control is active, a combinatorial cell behaves as a registered one and its sum term is treated as zero.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low the register is 0 and `cfg_i` is captured. Right after reset with sum 0, `fb_o` is 0 and `pad_o` equals the invert bit (cfg bit 1).
- R2: `cfg_i` is sampled only during reset. Changing it while `rst_n` is high changes no output.
- R3: With cfg bit 0 = 1 (combinatorial), `fb_o` equals `sum_i` in the same cycle, and `pad_o` equals `sum_i` XOR the invert bit.
- R4: With cfg bit 0 = 0 and cfg bit 2 = 0 (D behaviour), a selected clock strobe loads `sum_i` into the register. `fb_o` shows the register, and `pad_o` is `fb_o` XOR the invert bit.
- R5: With cfg bit 2 = 1 (T behaviour), a selected strobe inverts the register when `sum_i` is 1 and keeps it when `sum_i` is 0.
- R6: cfg bits 4:3 select the global clock. Strobes on the other clocks leave the register unchanged.
- R7: `ar_i` clears and `ap_i` sets the register on the next system edge, with or without a strobe. When both are high, clear wins.
- R8: cfg bits 6:5 set the pin enable: 0 = off, 1 = on, 2 = follow `oe_a_i`, 3 = follow `oe_b_i`.
- R9: `preload_i` loads `pad_i` into the register on the next edge and holds `pad_oe_o` low. Reset and preset take priority over it.
- R10: `observe_i` without preload forces `pad_oe_o` high whatever the enable setting.
- R11: While preload or observe is high, `fb_o` shows the register even in combinatorial mode, and the sum term is treated as 0. A T register therefore holds its value on a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset and configuration capture |
| cfg_i | input | 7 | Static configuration (fields listed in the requirements) |
| gclk_en_i | input | 4 | Rising-edge strobes of the global clocks |
| sum_i | input | 1 | Sum term from the product-term array |
| ar_i | input | 1 | Shared reset term |
| ap_i | input | 1 | Shared preset term |
| oe_a_i | input | 1 | First bank enable term |
| oe_b_i | input | 1 | Second bank enable term |
| pad_i | input | 1 | Level seen on the pin |
| preload_i | input | 1 | Test: load register from pin |
| observe_i | input | 1 | Test: force pin driver on |
| fb_o | output | 1 | Internal feedback value |
| pad_o | output | 1 | Pin output level after polarity |
| pad_oe_o | output | 1 | Pin driver enable |

## Verification
All 128 configurations are driven through the same pattern. First, strobes arrive only on the unselected clocks, which tells the clock selection apart from the combinatorial path. Next come two strobes on the selected clock with the sum held at 1, which separates D behaviour (the value stays 1) from T behaviour (the value returns to 0). A vector sequence runs a T register through mixed strobe masks and sum values. Directed cases then cover reset and preset applied together, preload against reset, and observe on a combinatorial cell, where the register value rather than the sum must appear.

// File: rtl/pld_macrocell.sv
module pld_macrocell #(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = $clog2(NUM_CLK)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W+4:0]   cfg_i,
  input  logic [NUM_CLK-1:0] gclk_en_i,
  input  logic               sum_i,
  input  logic               ar_i,
  input  logic               ap_i,
  input  logic               oe_a_i,
  input  logic               oe_b_i,
  input  logic               pad_i,
  input  logic               preload_i,
  input  logic               observe_i,
  output logic               fb_o,
  output logic               pad_o,
  output logic               pad_oe_o
);
  localparam int CFG_W = SEL_W + 5;

  logic [CFG_W-1:0] cfg_q;
  logic             q;
  logic             test_mode, eff_sum, strobe, value;
  logic             c_comb, c_inv, c_tff;
  logic [SEL_W-1:0] c_sel;
  logic [1:0]       c_oe;

  always_ff @(posedge clk)
    if (!rst_n) cfg_q <= cfg_i;

  assign c_comb = cfg_q[0];
  assign c_inv  = cfg_q[1];
  assign c_tff  = cfg_q[2];
  assign c_sel  = cfg_q[SEL_W+2:3];
  assign c_oe   = cfg_q[SEL_W+4:SEL_W+3];

  assign test_mode = preload_i | observe_i;
  assign eff_sum   = sum_i & ~test_mode;
  assign strobe    = gclk_en_i[c_sel];

  always_ff @(posedge clk) begin
    if (!rst_n)         q <= 1'b0;
    else if (ar_i)      q <= 1'b0;
    else if (ap_i)      q <= 1'b1;
    else if (preload_i) q <= pad_i;
    else if (strobe)    q <= c_tff ? (q ^ eff_sum) : eff_sum;
  end

  assign value = (c_comb & ~test_mode) ? eff_sum : q;
  assign fb_o  = value;
  assign pad_o = value ^ c_inv;

  always_comb begin
    if (preload_i)      pad_oe_o = 1'b0;
    else if (observe_i) pad_oe_o = 1'b1;
    else begin
      unique case (c_oe)
        2'd0:    pad_oe_o = 1'b0;
        2'd1:    pad_oe_o = 1'b1;
        2'd2:    pad_oe_o = oe_a_i;
        default: pad_oe_o = oe_b_i;
      endcase
    end
  end
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int CFG_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ar_i,
  input logic             ap_i,
  input logic             pad_i,
  input logic             preload_i,
  input logic             observe_i,
  input logic             q,
  input logic             pad_oe_o,
  input logic [CFG_W-1:0] cfg_q
);
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ar_i |=> !q);
  p_preset_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_i && !ar_i) |=> q);
  p_preload_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (preload_i && !ar_i && !ap_i) |=> (q == $past(pad_i)));
  p_preload_oe_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    preload_i |-> !pad_oe_o);
  p_observe_oe_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (observe_i && !preload_i) |-> pad_oe_o);
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q));
endmodule

bind pld_macrocell pld_macrocell_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ar_i(ar_i), .ap_i(ap_i), .pad_i(pad_i),
  .preload_i(preload_i), .observe_i(observe_i), .q(q),
  .pad_oe_o(pad_oe_o), .cfg_q(cfg_q)
);

// File: tb/test_pld_macrocell.sv
module test_pld_macrocell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cfg = '0;
  logic [3:0] en = '0;
  logic sum = 0, ar = 0, ap = 0, oe_a = 0, oe_b = 0, pad_in = 0, pre = 0, obs = 0;
  logic fb, pad, oe;
  int runs = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pld_macrocell i_pld_macrocell (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .gclk_en_i(en), .sum_i(sum),
    .ar_i(ar), .ap_i(ap), .oe_a_i(oe_a), .oe_b_i(oe_b), .pad_i(pad_in),
    .preload_i(pre), .observe_i(obs), .fb_o(fb), .pad_o(pad), .pad_oe_o(oe)
  );

  // T behaviour, clock 2 selected: {sum, strobes[3:0], expected fb}
  localparam logic [5:0] VEC [8] = '{
    6'b1_0100_1, 6'b1_0100_0, 6'b0_0100_0, 6'b1_0010_0,
    6'b1_0100_1, 6'b0_1011_1, 6'b1_1111_0, 6'b1_0100_1
  };

  task automatic chk(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic [6:0] c);
    @(negedge clk);
    rst_n = 0; cfg = c; en = 0; sum = 0; ar = 0; ap = 0; pre = 0; obs = 0;
    cyc(); cyc();
    @(negedge clk); rst_n = 1; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    oe_a = 1; oe_b = 0;
    for (int c = 0; c < 128; c++) begin
      logic comb, inv, tff, oexp;
      logic [1:0] sel, om;
      comb = c[0]; inv = c[1]; tff = c[2]; sel = c[4:3]; om = c[6:5];
      oexp = (om == 0) ? 1'b0 : (om == 1) ? 1'b1 : (om == 2) ? oe_a : oe_b;
      do_reset(7'(c));
      chk("R1 fb after reset", fb, 1'b0);
      chk("R1 pad after reset", pad, inv);
      @(negedge clk); sum = 1; en = ~(4'b1 << sel); cyc();
      chk("R6 other clocks / R3 comb", fb, comb);
      @(negedge clk); en = 4'b1 << sel; cyc();
      chk("R4 R5 first strobe", fb, 1'b1);
      cyc();
      chk("R4 R5 second strobe", fb, comb ? 1'b1 : !tff);
      chk("R3 R4 pad polarity", pad, (comb ? 1'b1 : !tff) ^ inv);
      chk("R8 enable mode", oe, oexp);
      @(negedge clk); en = 0; cfg = ~7'(c); cyc();
      chk("R2 cfg ignored fb", fb, comb ? 1'b1 : !tff);
      chk("R2 cfg ignored pad", pad, (comb ? 1'b1 : !tff) ^ inv);
      chk("R2 cfg ignored oe", oe, oexp);
    end

    do_reset(7'b0010100);
    foreach (VEC[k]) begin
      @(negedge clk); sum = VEC[k][5]; en = VEC[k][4:1]; cyc();
      chk("R5 R6 toggle vector", fb, VEC[k][0]);
    end

    do_reset(7'b0100000);
    @(negedge clk); en = 0; ap = 1; cyc();
    chk("R7 preset", fb, 1'b1);
    @(negedge clk); ar = 1; ap = 1; cyc();
    chk("R7 clear over preset", fb, 1'b0);
    @(negedge clk); ar = 0; cyc();
    chk("R7 preset alone again", fb, 1'b1);
    @(negedge clk); ap = 0; ar = 1; sum = 1; en = 4'b0001; cyc();
    chk("R7 clear over strobe", fb, 1'b0);
    @(negedge clk); ar = 0; en = 0; pre = 1; pad_in = 1; #1;
    chk("R9 preload enable low", oe, 1'b0);
    cyc();
    chk("R9 preload loads 1", fb, 1'b1);
    @(negedge clk); pad_in = 0; cyc();
    chk("R9 preload loads 0", fb, 1'b0);
    @(negedge clk); pad_in = 1; ar = 1; cyc();
    chk("R9 clear over preload", fb, 1'b0);
    @(negedge clk); ar = 0; pre = 0; #1;
    chk("R8 enable on after test", oe, 1'b1);

    do_reset(7'b0000001);
    @(negedge clk); pre = 1; pad_in = 1; sum = 1; cyc();
    @(negedge clk); pre = 0; obs = 1; sum = 0; #1;
    chk("R10 observe enable", oe, 1'b1);
    chk("R11 observe shows register", fb, 1'b1);
    @(negedge clk); obs = 0; #1;
    chk("R3 comb restored", fb, 1'b0);
    chk("R8 enable off restored", oe, 1'b0);

    do_reset(7'b0000100);
    @(negedge clk); pre = 1; pad_in = 1; cyc();
    @(negedge clk); pre = 0; obs = 1; sum = 1; en = 4'b0001; cyc();
    chk("R11 T holds in observe", fb, 1'b1);
    @(negedge clk); obs = 0; cyc();
    chk("R5 T toggles after observe", fb, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule